// File: doc/BRIEF.md
# Floppy Write-Latch Serializer

This block is the write half of a floppy controller that software drives through address-only soft switches. Each access to the controller's sixteen-location I/O window changes one switch, and bit 0 of the address gives the new value. Two of these switches, called Q6 and Q7 here, together select one of four modes: read, write-protect sense, write, or load of the write latch. A third switch turns the drive motor on or off. All switch changes are sampled on a 2 MHz enable tick, and only when the bus-phase qualifier and the device select are both active.

Software places a byte in the write latch with a store to offset 0xD while Q7 is set. It then starts the shifter with a store to offset 0xC. The shifter sends the byte out most significant bit first, one bit cell every 8 ticks (4 µs), so a full byte takes 64 ticks. A 1 bit toggles the flux line and a 0 bit leaves it alone. At every byte boundary the shifter takes the current latch contents. If software has not refilled the latch in time, the previous byte goes out again, so the bit-cell timing never gaps. In sense mode, software can read the write-protect level in data bit 7.

Top module: `fws_top`

## Requirements
- R1: While reset is held, Q6, Q7, the motor flag, the write latch and the shifter are cleared. After reset the flux line is 0, wr_req is 0 and rd_data is 0x00. A shift started after reset with no latch load therefore produces no flux transitions.
- R2: A switch changes only on a clock with tick, bus_phase and dev_sel all high. On such an access, addr 0x8/0x9 sets the motor flag, 0xC/0xD sets Q6 and 0xE/0xF sets Q7, each to addr bit 0. Accesses are ignored when bus_phase is low or when tick is low.
- R3: wr_req is 1 exactly when Q7 is 1 and the motor flag is 1.
- R4: rd_data equals {wp, 7'b0} when dev_sel is high, cpu_we is 0, addr is 0xE, Q7 is 0 and Q6 is 1. rd_data is 0x00 in every other case.
- R5: A store (cpu_we=1) access to addr 0xD copies wr_data into the write latch only if Q7 was 1 before that access. If Q7 was 0, the store leaves the latch unchanged.
- R6: A store access to addr 0xC while Q7 was 1 starts the idle shifter, provided Q7 and the motor stay on and wp is 0. The first bit leaves on the next tick, and each later bit follows 8 ticks after the one before it. Bits go out MSB first: a 1 toggles flux and a 0 leaves it unchanged, and flux never changes between bit cells.
- R7: Each byte spans 64 ticks. The latch is sampled when a byte's first bit leaves, so a load made during a byte is sent as the next byte. When no new load arrives, the previous byte repeats.
- R8: While wp is 1 the shifter stops and flux holds its level.
- R9: Clearing Q7 or turning the motor off stops the shifter, and flux holds its level until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock pulse at 2 MHz |
| bus_phase | input | 1 | CPU bus phase qualifier for switch accesses |
| dev_sel | input | 1 | Controller I/O window selected |
| cpu_we | input | 1 | 1 = CPU store, 0 = CPU load |
| addr | input | 4 | Low nibble of the I/O address |
| wr_data | input | 8 | CPU data bus toward the controller |
| wp | input | 1 | Write-protect level of the medium, 1 = protected |
| rd_data | output | 8 | Byte returned to the CPU |
| wr_req | output | 1 | Write request to the drive |
| flux | output | 1 | Serial flux data to the drive |

## Verification
The hardest situation to reach is the byte boundary, where the shifter either takes a freshly loaded byte or repeats the old one. The bench controls every 2 MHz tick itself, so it can count ticks from the start store. It places a latch load in the middle of a byte and then sends no load for a whole byte. For each tick it records whether flux toggled and compares that against the expected bit, cell by cell. This check also catches off-by-one cell timing and a missing repeat. The ignored-load case is reached the same way: Q7 is cleared first, then a store to 0xD is made, and the next stream is checked for the old byte.

// File: rtl/fws_pkg.sv
package fws_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        OFS_MOTOR_OFF = 4'h8,
        OFS_MOTOR_ON  = 4'h9,
        OFS_SHIFT     = 4'hC,
        OFS_LOAD      = 4'hD,
        OFS_SENSE     = 4'hE,
        OFS_WMODE     = 4'hF
    } ofs_e;

    typedef struct packed {
        logic              q6;
        logic              q7;
        logic              motor;
        logic [BYTE_W-1:0] latch;
    } sw_state_t;

endpackage

// File: rtl/fws_switches.sv
module fws_switches
    import fws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_phase,
    input  logic              dev_sel,
    input  logic              cpu_we,
    input  logic [3:0]        addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              q6,
    output logic              q7,
    output logic              motor,
    output logic              run_ok,
    output logic              start_req,
    output logic [BYTE_W-1:0] latch
);

    sw_state_t sw_d, sw_q;
    logic      access;

    always_comb begin
        sw_d      = sw_q;
        access    = tick && bus_phase && dev_sel;
        start_req = 1'b0;
        if (access) begin
            if (addr[3]) begin
                case (addr[2:1])
                    2'b00:   sw_d.motor = addr[0];
                    2'b10:   sw_d.q6    = addr[0];
                    2'b11:   sw_d.q7    = addr[0];
                    default: ;
                endcase
            end
            if (cpu_we && sw_q.q7 && addr == OFS_LOAD)
                sw_d.latch = wr_data;
            if (cpu_we && sw_q.q7 && addr == OFS_SHIFT)
                start_req = 1'b1;
        end
        run_ok = sw_d.q7 && sw_d.motor;
    end

    always_ff @(posedge clk) begin
        if (rst) sw_q <= '0;
        else     sw_q <= sw_d;
    end

    assign q6    = sw_q.q6;
    assign q7    = sw_q.q7;
    assign motor = sw_q.motor;
    assign latch = sw_q.latch;

endmodule

// File: rtl/fws_shifter.sv
module fws_shifter
    import fws_pkg::*;
#(
    parameter int CELL_TICKS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run_ok,
    input  logic              wp,
    input  logic              start_req,
    input  logic [BYTE_W-1:0] latch,
    output logic              flux
);

    localparam int CNT_W = (CELL_TICKS > 1) ? $clog2(CELL_TICKS) : 1;
    localparam int IDX_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CELL_LAST = CNT_W'(CELL_TICKS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(BYTE_W - 1);

    typedef struct packed {
        logic              active;
        logic              flux;
        logic [BYTE_W-1:0] shreg;
        logic [IDX_W-1:0]  bit_idx;
        logic [CNT_W-1:0]  cell_cnt;
    } sh_state_t;

    sh_state_t         sh_d, sh_q;
    logic [BYTE_W-1:0] cur_byte;

    always_comb begin
        sh_d     = sh_q;
        cur_byte = (sh_q.bit_idx == '0) ? latch : sh_q.shreg;
        if (!(run_ok && !wp)) begin
            sh_d.active = 1'b0;
        end else if (tick) begin
            if (sh_q.active) begin
                if (sh_q.cell_cnt == '0) begin
                    sh_d.flux     = sh_q.flux ^ cur_byte[BYTE_W-1];
                    sh_d.shreg    = cur_byte << 1;
                    sh_d.bit_idx  = (sh_q.bit_idx == IDX_LAST) ? '0 : sh_q.bit_idx + 1'b1;
                    sh_d.cell_cnt = CELL_LAST;
                end else begin
                    sh_d.cell_cnt = sh_q.cell_cnt - 1'b1;
                end
            end else if (start_req) begin
                sh_d.active   = 1'b1;
                sh_d.bit_idx  = '0;
                sh_d.cell_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign flux = sh_q.flux;

endmodule

// File: rtl/fws_top.sv
module fws_top
    import fws_pkg::*;
#(
    parameter int CELL_TICKS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_phase,
    input  logic              dev_sel,
    input  logic              cpu_we,
    input  logic [3:0]        addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wp,
    output logic [BYTE_W-1:0] rd_data,
    output logic              wr_req,
    output logic              flux
);

    logic              q6, q7, motor, run_ok, start_req;
    logic [BYTE_W-1:0] latch;

    fws_switches u_switches (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_phase (bus_phase),
        .dev_sel   (dev_sel),
        .cpu_we    (cpu_we),
        .addr      (addr),
        .wr_data   (wr_data),
        .q6        (q6),
        .q7        (q7),
        .motor     (motor),
        .run_ok    (run_ok),
        .start_req (start_req),
        .latch     (latch)
    );

    fws_shifter #(.CELL_TICKS(CELL_TICKS)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .run_ok    (run_ok),
        .wp        (wp),
        .start_req (start_req),
        .latch     (latch),
        .flux      (flux)
    );

    always_comb begin
        rd_data = '0;
        if (dev_sel && !cpu_we && addr == OFS_SENSE && q6 && !q7)
            rd_data[BYTE_W-1] = wp;
    end

    assign wr_req = q7 && motor;

endmodule

// File: rtl/fws_checker.sv
module fws_checker
    import fws_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bus_phase,
    input logic              dev_sel,
    input logic              cpu_we,
    input logic [3:0]        addr,
    input logic              wp,
    input logic [BYTE_W-1:0] rd_data,
    input logic              wr_req,
    input logic              flux
);

    // R1: leaving reset gives idle outputs
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!flux && !wr_req));

    // R2: write request only moves on a qualified access
    assert_switch_qualified_R2: assert property (@(posedge clk) disable iff (rst)
        !(tick && bus_phase && dev_sel) |=> $stable(wr_req));

    // R4: read-back is nonzero only for a sense read of a protected medium
    assert_sense_only_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_data != '0) |-> (dev_sel && !cpu_we && addr == OFS_SENSE && wp));

    // R6: flux changes only on a tick
    assert_flux_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(flux));

    // R8: protected medium never sees a transition
    assert_protect_hold_R8: assert property (@(posedge clk) disable iff (rst)
        wp |=> $stable(flux));

    // R9: no transition without a write request
    assert_stop_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> $stable(flux));

endmodule

bind fws_top fws_checker u_fws_checker (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_phase (bus_phase),
    .dev_sel   (dev_sel),
    .cpu_we    (cpu_we),
    .addr      (addr),
    .wp        (wp),
    .rd_data   (rd_data),
    .wr_req    (wr_req),
    .flux      (flux)
);

// File: tb/fws_top_bench.sv
module fws_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       bus_phase = 1'b0;
    logic       dev_sel = 1'b0;
    logic       cpu_we = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wr_data = 8'h00;
    logic       wp = 1'b0;
    logic [7:0] rd_data;
    logic       wr_req;
    logic       flux;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic prev_flux;

    always #10 clk = ~clk;

    fws_top u_fws_top (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_phase (bus_phase),
        .dev_sel   (dev_sel),
        .cpu_we    (cpu_we),
        .addr      (addr),
        .wr_data   (wr_data),
        .wp        (wp),
        .rd_data   (rd_data),
        .wr_req    (wr_req),
        .flux      (flux)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one 2 MHz period (25 clocks); optional access on its tick
    task automatic step(input bit acc, input bit bp, input logic [3:0] a,
                        input bit we, input logic [7:0] d);
        @(negedge clk);
        tick      = 1'b1;
        dev_sel   = acc;
        bus_phase = bp;
        addr      = a;
        cpu_we    = we;
        wr_data   = d;
        @(negedge clk);
        tick    = 1'b0;
        dev_sel = 1'b0;
        bus_phase = 1'b0;
        cpu_we  = 1'b0;
        repeat (23) @(negedge clk);
    endtask

    task automatic idle_step();
        step(1'b0, 1'b0, 4'h0, 1'b0, 8'h00);
    endtask

    task automatic sw(input logic [3:0] a, input bit we, input logic [7:0] d);
        step(1'b1, 1'b1, a, we, d);
        prev_flux = flux;
    endtask

    // 64 ticks after a start or a previous byte; compare each toggle
    task automatic shift_and_check(input logic [7:0] exp, input int load_at,
                                   input logic [7:0] load_val, input string req);
        for (int k = 1; k <= 64; k++) begin
            bit want;
            if (k == load_at) step(1'b1, 1'b1, 4'hD, 1'b1, load_val);
            else              idle_step();
            want = ((k - 1) % 8 == 0) ? exp[7 - (k - 1) / 8] : 1'b0;
            check((flux ^ prev_flux) == want, req, int'(flux ^ prev_flux), int'(want));
            prev_flux = flux;
        end
    endtask

    task automatic quiet_steps(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            idle_step();
            check(flux == prev_flux, req, int'(flux), int'(prev_flux));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(flux == 1'b0, "R1 flux idle", int'(flux), 0);
        check(wr_req == 1'b0, "R1 wr_req", int'(wr_req), 0);
        check(rd_data == 8'h00, "R1 rd_data", int'(rd_data), 0);
        prev_flux = flux;
        sw(4'h9, 1'b0, 8'h00);
        sw(4'hF, 1'b0, 8'h00);
        sw(4'hC, 1'b1, 8'h00);
        shift_and_check(8'h00, 0, 8'h00, "R1 latch cleared");
        sw(4'hE, 1'b0, 8'h00);
        sw(4'h8, 1'b0, 8'h00);
    endtask

    task automatic t_switches();
        step(1'b1, 1'b0, 4'h9, 1'b0, 8'h00);
        step(1'b1, 1'b0, 4'hF, 1'b0, 8'h00);
        check(wr_req == 1'b0, "R2 bus_phase low ignored", int'(wr_req), 0);
        @(negedge clk);
        dev_sel = 1'b1; bus_phase = 1'b1; addr = 4'hF;
        repeat (3) @(negedge clk);
        dev_sel = 1'b0; bus_phase = 1'b0;
        @(negedge clk);
        check(wr_req == 1'b0, "R2 no tick ignored", int'(wr_req), 0);
        sw(4'hF, 1'b0, 8'h00);
        check(wr_req == 1'b0, "R3 q7 without motor", int'(wr_req), 0);
        sw(4'h9, 1'b0, 8'h00);
        check(wr_req == 1'b1, "R3 q7 and motor", int'(wr_req), 1);
        sw(4'h8, 1'b0, 8'h00);
        check(wr_req == 1'b0, "R3 motor off", int'(wr_req), 0);
        sw(4'hE, 1'b0, 8'h00);
    endtask

    task automatic t_sense();
        sw(4'hD, 1'b0, 8'h00);
        sw(4'hE, 1'b0, 8'h00);
        @(negedge clk);
        dev_sel = 1'b1; cpu_we = 1'b0; addr = 4'hE; wp = 1'b1;
        #1 check(rd_data == 8'h80, "R4 sense protected", int'(rd_data), 8'h80);
        wp = 1'b0;
        #1 check(rd_data == 8'h00, "R4 sense writable", int'(rd_data), 0);
        wp = 1'b1; addr = 4'hC;
        #1 check(rd_data == 8'h00, "R4 other offset", int'(rd_data), 0);
        @(negedge clk);
        dev_sel = 1'b0; wp = 1'b0;
        sw(4'hC, 1'b0, 8'h00);
        @(negedge clk);
        dev_sel = 1'b1; addr = 4'hE; wp = 1'b1;
        #1 check(rd_data == 8'h00, "R4 read mode", int'(rd_data), 0);
        @(negedge clk);
        dev_sel = 1'b0; wp = 1'b0;
    endtask

    task automatic t_stream();
        sw(4'h9, 1'b0, 8'h00);
        sw(4'hF, 1'b0, 8'h00);
        sw(4'hD, 1'b1, 8'hA5);
        sw(4'hC, 1'b1, 8'h00);
        shift_and_check(8'hA5, 30, 8'h3C, "R6 msb first");
        shift_and_check(8'h3C, 0, 8'h00, "R7 mid-byte load");
        shift_and_check(8'h3C, 0, 8'h00, "R7 underrun repeat");
    endtask

    task automatic t_stop_and_ignore();
        sw(4'hE, 1'b0, 8'h00);
        check(wr_req == 1'b0, "R9 q7 cleared", int'(wr_req), 0);
        quiet_steps(20, "R9 stopped by q7");
        sw(4'hD, 1'b1, 8'hFF);
        sw(4'hF, 1'b0, 8'h00);
        sw(4'hC, 1'b1, 8'h00);
        shift_and_check(8'h3C, 0, 8'h00, "R5 load ignored");
        sw(4'h8, 1'b0, 8'h00);
        quiet_steps(20, "R9 stopped by motor");
    endtask

    task automatic t_protect();
        sw(4'h9, 1'b0, 8'h00);
        wp = 1'b1;
        sw(4'hD, 1'b1, 8'hFF);
        sw(4'hC, 1'b1, 8'h00);
        quiet_steps(64, "R8 protected");
        wp = 1'b0;
        sw(4'hC, 1'b1, 8'h00);
        shift_and_check(8'hFF, 0, 8'h00, "R8 resumes after protect");
    endtask

    initial begin
        prev_flux = 1'b0;
        t_reset();
        t_switches();
        t_sense();
        t_stream();
        t_stop_and_ignore();
        t_protect();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule